// File: doc/BRIEF.md
# CCD Frame Drive Timing Generator

This block produces every logic-level drive signal that a progressive-scan interline CCD needs. The input clock runs at a fixed multiple (`SUBPH`) of the pixel rate. Inside each pixel period it makes the two complementary horizontal transfer clocks and a one-clock reset-gate pulse. Per line it makes an active-low horizontal sync and a blanking flag. Per frame it makes an active-low vertical sync. The defaults are a 780-pixel line and a 525-line frame, which read the whole sensor in about 1/30 s at 12.27 MHz.

The three vertical phases are driven as three-level codes so that an external level shifter can reproduce the low, middle and readout voltages. During horizontal blanking on ordinary lines, a vertical state machine walks the phases through a five-step sequence that moves the charge down one line. On the single readout line it instead raises phases two and three to the readout level, and this is how the sensor readout pulse is formed. While either vertical action runs, the horizontal clocks are frozen.

A substrate discharge pulse, which acts as the electronic shutter, is issued in the blanking of every line whose number is below a shutter setting. That setting is captured only at reset and at the start of each frame. The vertical state machine has these states:
- `VS_HOLD`: the idle pattern.
- `VS_P1` to `VS_P5`: the transfer steps, each held for `VSTEP` pixels. The machine moves P1→P2→P3→P4→P5→HOLD.
- `VS_READ`: held for `RD_LEN` pixels, then back to HOLD.

From HOLD, the machine moves to P1 when the next pixel is column `VX_START` on any line other than `READ_ROW`. It moves to READ when the next pixel is column `RD_START` on line `READ_ROW`.

Top module: `ccd_timing_gen`

## Requirements
- R1: While `rst` is high, all outputs sit at their idle levels: h1=1, h2=0, rg=0, hsync_n=1, vsync_n=1, blank=1, sub=0, and v1/v2/v3 = low/mid/mid. In the first cycle after `rst` falls, the block shows pixel 0 of line 0, sub-phase 0.
- R2: Outside vertical activity, h1 is high for the first `SUBPH/2` clocks of each pixel period and h2 is its complement. rg is high only in the first clock of each pixel period.
- R3: hsync_n is low for pixels 0 to `HS_PIX-1` of each line. blank is high for pixels 0 to `BLANK_PIX-1`.
- R4: vsync_n is low on lines 0 to `VS_LINES-1` of each frame.
- R5: A line lasts `LINE_PIX*SUBPH` clocks and a frame lasts `FRAME_LINES` lines. Both counts wrap to zero.
- R6: The level codes are 00=low, 01=mid, 10=high. On every line except `READ_ROW`, starting at pixel `VX_START`, (v1,v2,v3) step through (low,low,mid), (mid,low,mid), (mid,low,low), (mid,mid,low) and (low,mid,low), each for `VSTEP` pixels. At all other times the phases hold (low,mid,mid).
- R7: On line `READ_ROW`, (v1,v2,v3) = (low,high,high) for `RD_LEN` pixels from pixel `RD_START`, and that line carries no transfer steps.
- R8: While the vertical phases differ from the idle pattern, h1=1, h2=0 and rg=0.
- R9: sub is high for pixels `SUB_START` to `SUB_START+SUB_LEN-1` on every line whose number is below the captured shutter setting. A setting of 0 gives no pulses. A setting of `FRAME_LINES` or more pulses every line.
- R10: The shutter setting is captured during reset and on the last clock of each frame only. A change in the middle of a frame has no effect on `sub` until the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, `SUBPH` times the pixel rate |
| rst | input | 1 | Synchronous active-high reset |
| shut_line | input | $clog2(FRAME_LINES+1) | Line number at which substrate pulses stop |
| h1 | output | 1 | Horizontal transfer phase 1 |
| h2 | output | 1 | Horizontal transfer phase 2 |
| rg | output | 1 | Reset gate pulse |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| blank | output | 1 | Horizontal blanking flag |
| v1 | output | 2 | Vertical phase 1 level code |
| v2 | output | 2 | Vertical phase 2 level code (carries the readout level) |
| v3 | output | 2 | Vertical phase 3 level code (carries the readout level) |
| sub | output | 1 | Substrate discharge pulse |

## Verification
The bench builds the block with four clocks per pixel, a 40-pixel line, a 10-line frame, 2-pixel transfer steps and the readout on line 3. One frame is then 1600 clocks, so reset, several whole frames, and both frame wraps happen within a few thousand cycles. With a short frame, the shutter settings 0, 10 (exactly the frame length) and 15 (above it) can all be reached, along with a change in the middle of a frame and a reset in the middle of a frame. Four clocks per pixel make the half-period of h1 and the single-clock rg pulse distinguishable.

// File: rtl/ccd_tg_pkg.sv
package ccd_tg_pkg;

    // Three-level drive code for a vertical phase
    typedef enum logic [1:0] {
        VL_LOW  = 2'b00,
        VL_MID  = 2'b01,
        VL_HIGH = 2'b10
    } vlev_t;

    // Vertical sequencer states
    typedef enum logic [2:0] {
        VS_HOLD,
        VS_P1,
        VS_P2,
        VS_P3,
        VS_P4,
        VS_P5,
        VS_READ
    } vstate_t;

endpackage

// File: rtl/ccd_tg_count.sv
module ccd_tg_count #(
    parameter int SUBPH       = 2,
    parameter int LINE_PIX    = 780,
    parameter int FRAME_LINES = 525,
    localparam int SW = (SUBPH > 1) ? $clog2(SUBPH) : 1,
    localparam int CW = $clog2(LINE_PIX),
    localparam int RW = $clog2(FRAME_LINES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [SW-1:0] sp,
    output logic [CW-1:0] col,
    output logic [RW-1:0] row,
    output logic          pix_tick,
    output logic          line_end,
    output logic          frame_end,
    output logic [CW-1:0] col_nxt,
    output logic [RW-1:0] row_nxt
);

    always_comb begin
        pix_tick  = (sp == SW'(SUBPH - 1));
        line_end  = pix_tick && (col == CW'(LINE_PIX - 1));
        frame_end = line_end && (row == RW'(FRAME_LINES - 1));
        col_nxt   = (col == CW'(LINE_PIX - 1)) ? '0 : col + 1'b1;
        if (line_end) begin
            row_nxt = (row == RW'(FRAME_LINES - 1)) ? '0 : row + 1'b1;
        end else begin
            row_nxt = row;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sp  <= '0;
            col <= '0;
            row <= '0;
        end else if (pix_tick) begin
            sp  <= '0;
            col <= col_nxt;
            row <= row_nxt;
        end else begin
            sp  <= sp + 1'b1;
        end
    end

    AST_COL_WRAP: assert property (@(posedge clk) disable iff (rst)
        line_end |=> (col == '0)); // R5
    AST_ROW_STEADY: assert property (@(posedge clk) disable iff (rst)
        !line_end |=> $stable(row)); // R5
    AST_ROW_RANGE: assert property (@(posedge clk) disable iff (rst)
        row < RW'(FRAME_LINES)); // R5

endmodule

// File: rtl/ccd_tg_vseq.sv
module ccd_tg_vseq
    import ccd_tg_pkg::*;
#(
    parameter int LINE_PIX    = 780,
    parameter int FRAME_LINES = 525,
    parameter int VX_START    = 31,
    parameter int VSTEP       = 12,
    parameter int RD_START    = 31,
    parameter int RD_LEN      = 25,
    parameter int READ_ROW    = 7,
    localparam int CW   = $clog2(LINE_PIX),
    localparam int RW   = $clog2(FRAME_LINES + 1),
    localparam int MAXL = (VSTEP > RD_LEN) ? VSTEP : RD_LEN,
    localparam int KW   = $clog2(MAXL + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pix_tick,
    input  logic [CW-1:0] col_nxt,
    input  logic [RW-1:0] row_nxt,
    input  logic [RW-1:0] row,
    output vlev_t         v1,
    output vlev_t         v2,
    output vlev_t         v3,
    output logic          busy
);

    vstate_t       state_q, state_d;
    logic [KW-1:0] cnt_q, cnt_d;
    logic          step_done;

    assign step_done = (cnt_q == KW'(VSTEP - 1));

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= VS_HOLD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next-state logic, evaluated at pixel boundaries
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (pix_tick) begin
            unique case (state_q)
                VS_HOLD: begin
                    cnt_d = '0;
                    if (row_nxt == RW'(READ_ROW)) begin
                        if (col_nxt == CW'(RD_START)) state_d = VS_READ;
                    end else if (col_nxt == CW'(VX_START)) begin
                        state_d = VS_P1;
                    end
                end
                VS_P1: begin
                    cnt_d = step_done ? '0 : cnt_q + 1'b1;
                    if (step_done) state_d = VS_P2;
                end
                VS_P2: begin
                    cnt_d = step_done ? '0 : cnt_q + 1'b1;
                    if (step_done) state_d = VS_P3;
                end
                VS_P3: begin
                    cnt_d = step_done ? '0 : cnt_q + 1'b1;
                    if (step_done) state_d = VS_P4;
                end
                VS_P4: begin
                    cnt_d = step_done ? '0 : cnt_q + 1'b1;
                    if (step_done) state_d = VS_P5;
                end
                VS_P5: begin
                    cnt_d = step_done ? '0 : cnt_q + 1'b1;
                    if (step_done) state_d = VS_HOLD;
                end
                VS_READ: begin
                    if (cnt_q == KW'(RD_LEN - 1)) begin
                        cnt_d   = '0;
                        state_d = VS_HOLD;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: begin
                    cnt_d   = '0;
                    state_d = VS_HOLD;
                end
            endcase
        end
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            VS_HOLD: begin v1 = VL_LOW; v2 = VL_MID;  v3 = VL_MID;  end
            VS_P1:   begin v1 = VL_LOW; v2 = VL_LOW;  v3 = VL_MID;  end
            VS_P2:   begin v1 = VL_MID; v2 = VL_LOW;  v3 = VL_MID;  end
            VS_P3:   begin v1 = VL_MID; v2 = VL_LOW;  v3 = VL_LOW;  end
            VS_P4:   begin v1 = VL_MID; v2 = VL_MID;  v3 = VL_LOW;  end
            VS_P5:   begin v1 = VL_LOW; v2 = VL_MID;  v3 = VL_LOW;  end
            VS_READ: begin v1 = VL_LOW; v2 = VL_HIGH; v3 = VL_HIGH; end
            default: begin v1 = VL_LOW; v2 = VL_MID;  v3 = VL_MID;  end
        endcase
        busy = (state_q != VS_HOLD);
    end

    AST_READ_ON_READ_ROW: assert property (@(posedge clk) disable iff (rst)
        (state_q == VS_READ) |-> (row == RW'(READ_ROW))); // R7
    AST_NO_STEP_ON_READ_ROW: assert property (@(posedge clk) disable iff (rst)
        (state_q == VS_P1) |-> (row != RW'(READ_ROW))); // R7
    AST_STEP_ORDER: assert property (@(posedge clk) disable iff (rst)
        ($past(state_q) == VS_P1 && state_q != VS_P1) |-> (state_q == VS_P2)); // R6
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q < KW'(MAXL)); // R6

endmodule

// File: rtl/ccd_tg_hgen.sv
module ccd_tg_hgen #(
    parameter int SUBPH       = 2,
    parameter int LINE_PIX    = 780,
    parameter int FRAME_LINES = 525,
    parameter int HS_PIX      = 58,
    parameter int BLANK_PIX   = 120,
    parameter int VS_LINES    = 3,
    localparam int SW   = (SUBPH > 1) ? $clog2(SUBPH) : 1,
    localparam int CW   = $clog2(LINE_PIX),
    localparam int RW   = $clog2(FRAME_LINES + 1),
    localparam int HALF = SUBPH / 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] sp,
    input  logic [CW-1:0] col,
    input  logic [RW-1:0] row,
    input  logic          busy,
    output logic          h1,
    output logic          h2,
    output logic          rg,
    output logic          hsync_n,
    output logic          vsync_n,
    output logic          blank
);

    logic freeze;

    always_comb begin
        freeze  = rst || busy;
        h1      = freeze ? 1'b1 : (sp <  SW'(HALF));
        h2      = freeze ? 1'b0 : (sp >= SW'(HALF));
        rg      = !freeze && (sp == '0);
        hsync_n = rst || (col >= CW'(HS_PIX));
        blank   = rst || (col <  CW'(BLANK_PIX));
        vsync_n = rst || (row >= RW'(VS_LINES));
    end

    AST_H_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
        h1 != h2); // R2
    AST_RG_WITH_H1: assert property (@(posedge clk) disable iff (rst)
        rg |-> h1); // R2
    AST_HSYNC_IN_BLANK: assert property (@(posedge clk) disable iff (rst)
        !hsync_n |-> blank); // R3

endmodule

// File: rtl/ccd_tg_shutter.sv
module ccd_tg_shutter #(
    parameter int LINE_PIX    = 780,
    parameter int FRAME_LINES = 525,
    parameter int SUB_START   = 95,
    parameter int SUB_LEN     = 12,
    localparam int CW = $clog2(LINE_PIX),
    localparam int RW = $clog2(FRAME_LINES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frame_end,
    input  logic [RW-1:0] shut_line,
    input  logic [RW-1:0] row,
    input  logic [CW-1:0] col,
    output logic          sub
);

    logic [RW-1:0] shut_q;
    logic          in_win;

    always_ff @(posedge clk) begin
        if (rst || frame_end) begin
            shut_q <= shut_line;
        end
    end

    always_comb begin
        in_win = (int'(col) >= SUB_START) && (int'(col) < SUB_START + SUB_LEN);
        sub    = !rst && in_win && (row < shut_q);
    end

    AST_SETTING_HELD: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> $stable(shut_q)); // R10

endmodule

// File: rtl/ccd_timing_gen.sv
module ccd_timing_gen
    import ccd_tg_pkg::*;
#(
    parameter int SUBPH       = 2,
    parameter int LINE_PIX    = 780,
    parameter int FRAME_LINES = 525,
    parameter int HS_PIX      = 58,
    parameter int BLANK_PIX   = 120,
    parameter int VS_LINES    = 3,
    parameter int VX_START    = 31,
    parameter int VSTEP       = 12,
    parameter int RD_START    = 31,
    parameter int RD_LEN      = 25,
    parameter int READ_ROW    = 7,
    parameter int SUB_START   = 95,
    parameter int SUB_LEN     = 12,
    localparam int SW = (SUBPH > 1) ? $clog2(SUBPH) : 1,
    localparam int CW = $clog2(LINE_PIX),
    localparam int RW = $clog2(FRAME_LINES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [RW-1:0] shut_line,
    output logic          h1,
    output logic          h2,
    output logic          rg,
    output logic          hsync_n,
    output logic          vsync_n,
    output logic          blank,
    output logic [1:0]    v1,
    output logic [1:0]    v2,
    output logic [1:0]    v3,
    output logic          sub
);

    logic [SW-1:0] sp;
    logic [CW-1:0] col, col_nxt;
    logic [RW-1:0] row, row_nxt;
    logic          pix_tick, line_end, frame_end;
    vlev_t         v1_s, v2_s, v3_s;
    logic          busy_s, busy;

    ccd_tg_count #(
        .SUBPH(SUBPH), .LINE_PIX(LINE_PIX), .FRAME_LINES(FRAME_LINES)
    ) u_count (
        .clk(clk), .rst(rst), .sp(sp), .col(col), .row(row),
        .pix_tick(pix_tick), .line_end(line_end), .frame_end(frame_end),
        .col_nxt(col_nxt), .row_nxt(row_nxt)
    );

    ccd_tg_vseq #(
        .LINE_PIX(LINE_PIX), .FRAME_LINES(FRAME_LINES),
        .VX_START(VX_START), .VSTEP(VSTEP),
        .RD_START(RD_START), .RD_LEN(RD_LEN), .READ_ROW(READ_ROW)
    ) u_vseq (
        .clk(clk), .rst(rst), .pix_tick(pix_tick),
        .col_nxt(col_nxt), .row_nxt(row_nxt), .row(row),
        .v1(v1_s), .v2(v2_s), .v3(v3_s), .busy(busy_s)
    );

    assign busy = !rst && busy_s;

    ccd_tg_hgen #(
        .SUBPH(SUBPH), .LINE_PIX(LINE_PIX), .FRAME_LINES(FRAME_LINES),
        .HS_PIX(HS_PIX), .BLANK_PIX(BLANK_PIX), .VS_LINES(VS_LINES)
    ) u_hgen (
        .clk(clk), .rst(rst), .sp(sp), .col(col), .row(row), .busy(busy),
        .h1(h1), .h2(h2), .rg(rg), .hsync_n(hsync_n),
        .vsync_n(vsync_n), .blank(blank)
    );

    ccd_tg_shutter #(
        .LINE_PIX(LINE_PIX), .FRAME_LINES(FRAME_LINES),
        .SUB_START(SUB_START), .SUB_LEN(SUB_LEN)
    ) u_shutter (
        .clk(clk), .rst(rst), .frame_end(frame_end), .shut_line(shut_line),
        .row(row), .col(col), .sub(sub)
    );

    always_comb begin
        if (rst) begin
            v1 = VL_LOW;
            v2 = VL_MID;
            v3 = VL_MID;
        end else begin
            v1 = v1_s;
            v2 = v2_s;
            v3 = v3_s;
        end
    end

    AST_HOLD_HCLK: assert property (@(posedge clk) disable iff (rst)
        (v1 != VL_LOW || v2 != VL_MID || v3 != VL_MID) |-> (h1 && !h2 && !rg)); // R8
    AST_SUB_IN_BLANK: assert property (@(posedge clk) disable iff (rst)
        sub |-> blank); // R9
    AST_READ_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        (v2 == VL_HIGH) |-> (v3 == VL_HIGH && v1 == VL_LOW)); // R7

endmodule

// File: tb/ccd_timing_gen_test.sv
module ccd_timing_gen_test;

    localparam int SUBPH = 4, LINE_PIX = 40, FRAME_LINES = 10;
    localparam int HS_PIX = 4, BLANK_PIX = 24, VS_LINES = 2;
    localparam int VX_START = 3, VSTEP = 2, RD_START = 3, RD_LEN = 5, READ_ROW = 3;
    localparam int SUB_START = 15, SUB_LEN = 3;
    localparam int RW = $clog2(FRAME_LINES + 1);
    localparam int FRAME_CLKS = SUBPH * LINE_PIX * FRAME_LINES;
    localparam int WD_CYCLES = 20000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [RW-1:0] shut_line = RW'(4);
    logic          h1, h2, rg, hsync_n, vsync_n, blank, sub;
    logic [1:0]    v1, v2, v3;

    int n_chk = 0, n_fail = 0;
    int mk = 0, mshut = 0;
    bit done = 0, run_chk = 0;

    always #10 clk = ~clk;

    ccd_timing_gen #(
        .SUBPH(SUBPH), .LINE_PIX(LINE_PIX), .FRAME_LINES(FRAME_LINES),
        .HS_PIX(HS_PIX), .BLANK_PIX(BLANK_PIX), .VS_LINES(VS_LINES),
        .VX_START(VX_START), .VSTEP(VSTEP), .RD_START(RD_START),
        .RD_LEN(RD_LEN), .READ_ROW(READ_ROW),
        .SUB_START(SUB_START), .SUB_LEN(SUB_LEN)
    ) uut (
        .clk(clk), .rst(rst), .shut_line(shut_line),
        .h1(h1), .h2(h2), .rg(rg), .hsync_n(hsync_n), .vsync_n(vsync_n),
        .blank(blank), .v1(v1), .v2(v2), .v3(v3), .sub(sub)
    );

    // Behavioural position and shutter model, advanced at each edge
    always @(posedge clk) begin
        if (rst) begin
            mk = 0;
            mshut = int'(shut_line);
        end else if (mk == FRAME_CLKS - 1) begin
            mk = 0;
            mshut = int'(shut_line);
        end else begin
            mk = mk + 1;
        end
    end

    task automatic cmp(input string tag, input string nm,
                       input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s at t=%0t: actual %0d expected %0d",
                     tag, nm, $time, act, exp);
        end
    endtask

    task automatic check_all();
        int sp, col, row, e1, e2, e3, step;
        bit busy, readl;
        string vt, ht;
        if (rst) begin
            cmp("R1", "h1", 8'(h1), 8'd1);
            cmp("R1", "h2", 8'(h2), 8'd0);
            cmp("R1", "rg", 8'(rg), 8'd0);
            cmp("R1", "hsync_n", 8'(hsync_n), 8'd1);
            cmp("R1", "vsync_n", 8'(vsync_n), 8'd1);
            cmp("R1", "blank", 8'(blank), 8'd1);
            cmp("R1", "sub", 8'(sub), 8'd0);
            cmp("R1", "v1", 8'(v1), 8'd0);
            cmp("R1", "v2", 8'(v2), 8'd1);
            cmp("R1", "v3", 8'(v3), 8'd1);
            return;
        end
        sp  = mk % SUBPH;
        col = (mk / SUBPH) % LINE_PIX;
        row = mk / (SUBPH * LINE_PIX);
        readl = (row == READ_ROW);
        e1 = 0; e2 = 1; e3 = 1;
        if (readl && col >= RD_START && col < RD_START + RD_LEN) begin
            e1 = 0; e2 = 2; e3 = 2;
        end else if (!readl && col >= VX_START && col < VX_START + 5 * VSTEP) begin
            step = (col - VX_START) / VSTEP;
            case (step)
                0: begin e1 = 0; e2 = 0; e3 = 1; end
                1: begin e1 = 1; e2 = 0; e3 = 1; end
                2: begin e1 = 1; e2 = 0; e3 = 0; end
                3: begin e1 = 1; e2 = 1; e3 = 0; end
                default: begin e1 = 0; e2 = 1; e3 = 0; end
            endcase
        end
        busy = !(e1 == 0 && e2 == 1 && e3 == 1);
        vt = readl ? "R7" : "R6";
        ht = busy ? "R8" : "R2";
        cmp(vt, "v1", 8'(v1), 8'(e1));
        cmp(vt, "v2", 8'(v2), 8'(e2));
        cmp(vt, "v3", 8'(v3), 8'(e3));
        cmp(ht, "h1", 8'(h1), busy ? 8'd1 : 8'(sp < SUBPH / 2));
        cmp(ht, "h2", 8'(h2), busy ? 8'd0 : 8'(sp >= SUBPH / 2));
        cmp(ht, "rg", 8'(rg), busy ? 8'd0 : 8'(sp == 0));
        cmp("R3 R5", "hsync_n", 8'(hsync_n), 8'(col >= HS_PIX));
        cmp("R3 R5", "blank", 8'(blank), 8'(col < BLANK_PIX));
        cmp("R4 R5", "vsync_n", 8'(vsync_n), 8'(row >= VS_LINES));
        cmp("R9 R10", "sub", 8'(sub),
            8'(row < mshut && col >= SUB_START && col < SUB_START + SUB_LEN));
    endtask

    always @(negedge clk) begin
        #8;
        if (run_chk && !done) check_all();
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        run_chk = 1;
        // R1: reset with shutter setting 4
        cycles(3);
        rst = 1'b0;
        // R9: pulses on lines 0..3; change to 0 in the middle of frame 2 (R10)
        cycles(FRAME_CLKS + FRAME_CLKS / 2);
        shut_line = RW'(0);
        cycles(FRAME_CLKS);
        // R9: setting above the frame length pulses every line
        shut_line = RW'(15);
        cycles(FRAME_CLKS + 100);
        // R9: setting equal to the frame length
        shut_line = RW'(FRAME_LINES);
        cycles(FRAME_CLKS + 100);
        // R1 R10: reset in the middle of a frame captures a new setting
        shut_line = RW'(6);
        rst = 1'b1;
        cycles(2);
        shut_line = RW'(1);
        rst = 1'b0;
        cycles(FRAME_CLKS + 300);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL R5 watchdog: actual %0d cycles expected fewer", WD_CYCLES);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule